// File: doc/BRIEF.md
# Line Clamp Timing Generator

This block produces the per-line clamp window of a video digitizer, in the pixel clock domain. A horizontal sync input is resynchronized and watched for its trailing edge, the edge opposite to the leading edge that a programmable polarity bit picks out. From that trailing edge the block waits a programmable number of pixel clocks and then holds its clamp strobe for another programmable number of pixel clocks. This places the clamp in the back porch, where the video carries a known black level.

An enable bit hands clamp timing to an external clamp input with its own programmable sense. In that mode the internal window is ignored. The block also presents, for each colour channel, the code the converter should clamp to. Red and blue each choose ground (00h) or midscale (80h) with their own bit. Green always clamps to ground. All settings arrive as plain input pins, and every pin is a plain level with no handshake. There is no data stream, so no back-pressure applies.

Top module: `line_clamp_gen`

## Requirements
- R1: With `sync_pol_hi` = 0 the clamp window is timed from a rising edge of `hsync_in`, and with `sync_pol_hi` = 1 from a falling edge. The opposite (leading) edge starts nothing, and `clamp_active` stays low after it.
- R2: An `hsync_in` transition is first captured at a rising clock edge. A trailing edge captured at edge 1 makes `clamp_active` go high after rising edge 4 + `clamp_delay`.
- R3: Once high, `clamp_active` stays high for exactly `clamp_width` clock cycles and then falls.
- R4: A `clamp_width` of 0 produces no clamp pulse for that line.
- R5: A trailing edge that arrives during the delay count or the clamp pulse restarts the sequence from the new edge, with the delay and width it would have had alone.
- R6: With `ext_clamp_en` = 1, `clamp_active` follows the external clamp input 3 rising edges after the input is captured, and the internal window has no effect on it.
- R7: `ext_clamp_pol` = 1 treats a high external input as clamp active, and `ext_clamp_pol` = 0 treats a low external input as clamp active.
- R8: `red_target` is 80h when `red_mid_sel` = 1 and 00h otherwise. `blue_target` follows `blue_mid_sel` in the same way. `green_target` is always 00h.
- R9: While `rst_n` is low and after it is released with both inputs idle, `clamp_active` is low.
- R10: The extreme counts work: `clamp_delay` = 0 gives a clamp starting after rising edge 4, and `clamp_delay` = FFh gives one starting after edge 259.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| hsync_in | input | 1 | Horizontal sync, asynchronous |
| ext_clamp_in | input | 1 | External clamp request, asynchronous |
| sync_pol_hi | input | 1 | 1: sync leading edge is rising; 0: falling |
| clamp_delay | input | 8 | Pixel clocks from trailing sync edge to clamp start |
| clamp_width | input | 8 | Clamp length in pixel clocks |
| ext_clamp_en | input | 1 | 1: clamp taken from the external input |
| ext_clamp_pol | input | 1 | 1: external input active high |
| red_mid_sel | input | 1 | Red clamp target select |
| blue_mid_sel | input | 1 | Blue clamp target select |
| clamp_active | output | 1 | Registered clamp strobe |
| red_target | output | 8 | Red clamp code |
| green_target | output | 8 | Green clamp code |
| blue_target | output | 8 | Blue clamp code |

## Verification
The bench uses the default parameters: 8-bit counts, 8-bit codes and a two-stage synchronizer. With these it can reach the extreme delay of 255 and the extreme width of 255 within one run, and it can check the exact first-high cycle through the full synchronizer and register latency. The narrow code width keeps the midscale value at 80h, so the target checks compare directly against the stated codes. Restart during both the delay phase and the clamp phase is reachable because short delays are allowed.

// File: rtl/clamp_pkg.sv
package clamp_pkg;

  typedef enum logic [1:0] {
    WIN_IDLE  = 2'd0,
    WIN_DELAY = 2'd1,
    WIN_HOLD  = 2'd2
  } win_state_t;

  function automatic logic [7:0] mid_code8();
    return 8'h80;
  endfunction

endpackage

// File: rtl/clamp_sync.sv
module clamp_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/clamp_edge_det.sv
module clamp_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_s,
  input  logic lead_rising,
  output logic trail_pulse
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_s;
  end

  // leading edge rising -> trailing edge is falling, and vice versa
  always_comb begin
    if (lead_rising) trail_pulse = prev_q & ~sig_s;
    else             trail_pulse = ~prev_q & sig_s;
  end

  // R1: with a fixed polarity, a trailing edge is never reported twice in a row
  a_r1_single_trail: assert property (@(posedge clk) disable iff (!rst_n)
    trail_pulse |=> (!trail_pulse || !$stable(lead_rising)));

endmodule

// File: rtl/clamp_window_ctr.sv
module clamp_window_ctr
  import clamp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trail_pulse,
  input  logic [CNT_W-1:0] delay_cnt,
  input  logic [CNT_W-1:0] width_cnt,
  output logic             hold_on
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  win_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WIN_IDLE;
      cnt_q   <= '0;
    end else if (trail_pulse) begin
      if (width_cnt == '0) begin
        state_q <= WIN_IDLE;
        cnt_q   <= '0;
      end else if (delay_cnt == '0) begin
        state_q <= WIN_HOLD;
        cnt_q   <= width_cnt - ONE;
      end else begin
        state_q <= WIN_DELAY;
        cnt_q   <= delay_cnt - ONE;
      end
    end else begin
      unique case (state_q)
        WIN_DELAY: begin
          if (cnt_q == '0) begin
            if (width_cnt == '0) begin
              state_q <= WIN_IDLE;
            end else begin
              state_q <= WIN_HOLD;
              cnt_q   <= width_cnt - ONE;
            end
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        WIN_HOLD: begin
          if (cnt_q == '0) state_q <= WIN_IDLE;
          else             cnt_q   <= cnt_q - ONE;
        end
        default: begin
          state_q <= WIN_IDLE;
        end
      endcase
    end
  end

  assign hold_on = (state_q == WIN_HOLD);

  // R4: a zero width never leads into the clamp phase
  a_r4_zero_width: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_pulse && width_cnt == '0) |=> (state_q == WIN_IDLE));

  // R5: a trailing edge restarts the delay count from the programmed value
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_pulse && delay_cnt != '0 && width_cnt != '0)
      |=> (state_q == WIN_DELAY && cnt_q == $past(delay_cnt) - ONE));

  // R2: an expired delay enters the clamp phase loaded with the width
  a_r2_delay_to_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WIN_DELAY && cnt_q == '0 && !trail_pulse && width_cnt != '0)
      |=> (state_q == WIN_HOLD && cnt_q == $past(width_cnt) - ONE));

  // R3: the clamp phase ends when its count runs out
  a_r3_hold_end: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WIN_HOLD && cnt_q == '0 && !trail_pulse) |=> (state_q == WIN_IDLE));

endmodule

// File: rtl/line_clamp_gen.sv
module line_clamp_gen
  import clamp_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_in,
  input  logic              ext_clamp_in,
  input  logic              sync_pol_hi,
  input  logic [CNT_W-1:0]  clamp_delay,
  input  logic [CNT_W-1:0]  clamp_width,
  input  logic              ext_clamp_en,
  input  logic              ext_clamp_pol,
  input  logic              red_mid_sel,
  input  logic              blue_mid_sel,
  output logic              clamp_active,
  output logic [CODE_W-1:0] red_target,
  output logic [CODE_W-1:0] green_target,
  output logic [CODE_W-1:0] blue_target
);

  localparam logic [CODE_W-1:0] CODE_GND = '0;
  localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);

  logic [1:0] raw_in;
  logic [1:0] sync_in;
  logic       hs_s;
  logic       ext_s;
  logic       trail;
  logic       hold_on;
  logic       clamp_q;

  assign raw_in = {ext_clamp_in, hsync_in};

  clamp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (raw_in),
    .sync_out (sync_in)
  );

  assign hs_s  = sync_in[0];
  assign ext_s = sync_in[1];

  clamp_edge_det u_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .sig_s       (hs_s),
    .lead_rising (sync_pol_hi),
    .trail_pulse (trail)
  );

  clamp_window_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk         (clk),
    .rst_n       (rst_n),
    .trail_pulse (trail),
    .delay_cnt   (clamp_delay),
    .width_cnt   (clamp_width),
    .hold_on     (hold_on)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)            clamp_q <= 1'b0;
    else if (ext_clamp_en) clamp_q <= (ext_s == ext_clamp_pol);
    else                   clamp_q <= hold_on;
  end

  assign clamp_active = clamp_q;
  assign red_target   = red_mid_sel  ? CODE_MID : CODE_GND;
  assign blue_target  = blue_mid_sel ? CODE_MID : CODE_GND;
  assign green_target = CODE_GND;

  // R6: in external mode the strobe tracks the synchronized input, not the window
  a_r6_ext_follow: assert property (@(posedge clk) disable iff (!rst_n)
    ext_clamp_en |=> (clamp_active == ($past(ext_s) == $past(ext_clamp_pol))));

  // R3: in internal mode the strobe is the window one cycle later
  a_r3_internal_path: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_clamp_en |=> (clamp_active == $past(hold_on)));

endmodule

// File: tb/line_clamp_gen_test.sv
module line_clamp_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {leading-edge-rising, delay, width}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 8'h08, 8'h14},
    {1'b1, 8'h08, 8'h14},
    {1'b0, 8'h00, 8'h01},
    {1'b1, 8'h03, 8'h00},
    {1'b0, 8'hFF, 8'h02},
    {1'b1, 8'h01, 8'hFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync_in = 1'b0;
  logic ext_clamp_in = 1'b0;
  logic sync_pol_hi = 1'b1;
  logic [7:0] clamp_delay = 8'h08;
  logic [7:0] clamp_width = 8'h14;
  logic ext_clamp_en = 1'b0;
  logic ext_clamp_pol = 1'b1;
  logic red_mid_sel = 1'b0;
  logic blue_mid_sel = 1'b0;
  logic clamp_active;
  logic [7:0] red_target, green_target, blue_target;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_clamp_gen uut (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .ext_clamp_in(ext_clamp_in),
    .sync_pol_hi(sync_pol_hi), .clamp_delay(clamp_delay), .clamp_width(clamp_width),
    .ext_clamp_en(ext_clamp_en), .ext_clamp_pol(ext_clamp_pol),
    .red_mid_sel(red_mid_sel), .blue_mid_sel(blue_mid_sel),
    .clamp_active(clamp_active), .red_target(red_target),
    .green_target(green_target), .blue_target(blue_target)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one line: set polarity, leading edge, trailing edge, measure window
  task automatic run_line(input logic pol, input int dly, input int wid);
    logic idle_lvl;
    int first, cnt;
    sync_pol_hi = pol;
    clamp_delay = 8'(dly);
    clamp_width = 8'(wid);
    idle_lvl = pol ? 1'b0 : 1'b1;
    hsync_in = idle_lvl;
    idle(dly + wid + 12);
    hsync_in = ~idle_lvl;
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (clamp_active) cnt++;
    end
    chk("R1 leading edge starts nothing", cnt, 0);
    hsync_in = idle_lvl;
    first = 0;
    cnt = 0;
    for (int i = 1; i <= dly + wid + 8; i++) begin
      @(negedge clk);
      if (clamp_active) begin
        if (first == 0) first = i;
        cnt++;
      end
    end
    if (dly == 0 || dly == 255) chk("R10 extreme delay start", first, (wid == 0) ? 0 : 4 + dly);
    else if (wid == 0) chk("R4 zero width no pulse", first, 0);
    else chk("R2 delay start cycle", first, 4 + dly);
    chk(wid == 0 ? "R4 zero width count" : "R3 width count", cnt, wid);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int first, cnt;
    // R9: reset state
    idle(3);
    chk("R9 clamp low in reset", int'(clamp_active), 0);
    rst_n = 1'b1;
    idle(5);
    chk("R9 clamp low after reset", int'(clamp_active), 0);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      run_line(VEC[v][16], int'(VEC[v][15:8]), int'(VEC[v][7:0]));
    end

    // R5: restart during delay; pol=1 -> trailing is falling
    run_line(1'b1, 10, 5);
    hsync_in = 1'b1;
    idle(5);
    hsync_in = 1'b0;
    idle(5);
    hsync_in = 1'b1;
    idle(2);
    hsync_in = 1'b0;
    first = 0; cnt = 0;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (clamp_active) begin
        if (first == 0) first = i;
        cnt++;
      end
    end
    chk("R5 restart in delay start", first, 14);
    chk("R5 restart in delay width", cnt, 5);

    // R5: restart during clamp pulse
    clamp_delay = 8'd2;
    clamp_width = 8'd20;
    hsync_in = 1'b1;
    idle(4);
    hsync_in = 1'b0;
    idle(10);
    hsync_in = 1'b1;
    idle(2);
    hsync_in = 1'b0;
    cnt = 0;
    for (int i = 1; i <= 35; i++) begin
      @(negedge clk);
      if (i == 4) chk("R5 restart gap low", int'(clamp_active), 0);
      if (i == 6) chk("R5 restart clamp resumes", int'(clamp_active), 1);
      if (i >= 6 && clamp_active) cnt++;
    end
    chk("R5 restart full width", cnt, 20);

    // R6/R7: external clamp, active high
    ext_clamp_en = 1'b1;
    ext_clamp_pol = 1'b1;
    ext_clamp_in = 1'b0;
    clamp_delay = 8'd0;
    clamp_width = 8'd30;
    idle(5);
    hsync_in = 1'b1;
    idle(2);
    hsync_in = 1'b0;
    cnt = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (clamp_active) cnt++;
    end
    chk("R6 internal window ignored", cnt, 0);
    ext_clamp_in = 1'b1;
    idle(2);
    chk("R6 external latency not yet", int'(clamp_active), 0);
    idle(1);
    chk("R6 external follows after 3", int'(clamp_active), 1);
    ext_clamp_in = 1'b0;
    idle(3);
    chk("R7 active high released", int'(clamp_active), 0);
    ext_clamp_pol = 1'b0;
    idle(2);
    chk("R7 active low clamps on low input", int'(clamp_active), 1);
    ext_clamp_in = 1'b1;
    idle(3);
    chk("R7 active low released on high", int'(clamp_active), 0);
    ext_clamp_en = 1'b0;
    idle(40);

    // R8: targets
    for (int m = 0; m < 4; m++) begin
      red_mid_sel = m[0];
      blue_mid_sel = m[1];
      idle(1);
      chk("R8 red target", int'(red_target), m[0] ? 8'h80 : 8'h00);
      chk("R8 blue target", int'(blue_target), m[1] ? 8'h80 : 8'h00);
      chk("R8 green target", int'(green_target), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule